// File: doc/BRIEF.md
# Latched 32-bit SEC-DED correction unit

This block protects a 32-bit data word with 8 check bits using an odd-weight-column modified Hamming code. It corrects any single-bit data error and detects every double-bit error. Data and check bits enter through an enabled capture stage (the input latch). A mode pin selects between two modes. In generate mode the unit computes check bits for the held word. In detect/correct mode it computes a syndrome, raises active-low error flags and loads an output latch through a correction network.

The latches are modelled as edge-sampled registers. Each one captures at a rising clock edge while its enable is high and holds otherwise. Three-state pins appear as a value plus an active-high enable: each data byte has its own enable and the syndrome/check bus has one. A diagnostic latch captures the data input. When the code-select input reads 01, the correct control and the diagnostic mode come from that latch instead of the pins. A non-normal diagnostic mode replaces the received check bits with diagnostic check bits held in the latch.

Top module: `edac32_unit`

## Requirements
- R1: At a rising edge with `in_le` high, the data latch captures `din` and the check latch captures `cbin`. With `in_le` low, both hold their values.
- R2: With `gen_n` low (generate), `sc` carries the check bits of the data latch and both `err_n` and `merr_n` are 1. Data bit i has as its parity column the i-th smallest 8-bit value of weight 3, counting from 0 (bit 0 → 0x07, bit 1 → 0x0B, bit 2 → 0x0D, ...). Check bit j has the column with only bit j set. Each check bit is the XOR of the data bits whose column has a 1 in that row.
- R3: While `gen_n` is low, the output latch (`dout`) keeps its contents.
- R4: With `gen_n` high, `sc` equals the generated check bits XOR the used check bits. At every rising edge the output latch loads the result of the correction network.
- R5: If the effective correct control is 1 and the syndrome equals data column k, bit k is inverted on its way to the output latch. If the control is 0, the data passes unchanged.
- R6: With `gen_n` high:
  - a zero syndrome gives `err_n`=1 and `merr_n`=1;
  - a syndrome equal to any data or check column gives `err_n`=0 and `merr_n`=1;
  - any other nonzero syndrome gives both flags 0.
- R7: A syndrome equal to a check-bit column leaves the data unmodified, even with correction enabled.
- R8: `dout_en[b]` is the inverse of `oe_byte_n[b]` and gates `dout[8b+7:8b]`. `sc_en` is the inverse of `oe_sc_n`.
- R9: At a rising edge with `diag_le` high, the diagnostic latch captures bits 7:0 (diagnostic check bits), bits 19:18 (diagnostic mode) and bit 20 (correct control) of `din`. With `diag_le` low, it holds.
- R10: With `code_sel` equal to 01, the effective correct control is diagnostic bit 20 and the effective diagnostic mode is bits 19:18. Otherwise both come from the `correct` and `diag_mode` pins.
- R11: An effective diagnostic mode of 00 is normal operation. Any other value makes the syndrome use the diagnostic check bits in place of the check latch.
- R12: Reset (`rst_n` low) clears all latches to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Data input to the data and diagnostic latches |
| cbin | input | 8 | Received check bits |
| in_le | input | 1 | Capture enable for the data and check latches |
| gen_n | input | 1 | 0 = generate, 1 = detect/correct |
| correct | input | 1 | Correction enable from the pin |
| code_sel | input | 2 | Code select; 01 routes controls from the diagnostic latch |
| diag_mode | input | 2 | Diagnostic mode from the pin |
| diag_le | input | 1 | Capture enable for the diagnostic latch |
| oe_byte_n | input | 4 | Active-low per-byte data output enables |
| oe_sc_n | input | 1 | Active-low enable for the syndrome/check bus |
| dout | output | 32 | Output latch contents |
| dout_en | output | 4 | Per-byte drive enables |
| sc | output | 8 | Check bits or syndrome |
| sc_en | output | 1 | Drive enable for `sc` |
| err_n | output | 1 | Active-low error flag |
| merr_n | output | 1 | Active-low multiple-error flag |

## Verification
The hardest state to reach is a correction whose control comes from the diagnostic latch while that latch also supplies the check bits. Reaching it needs three steps in order: a diagnostic word loaded through the shared data input, the data latch then reloaded with a different word, and `code_sel` set to 01.

The stimulus walks that sequence on purpose. It then injects syndromes from the data side and the check side: single columns, check-bit columns, pairs, and a weight-3 value above the used columns.

A long random phase mixes enables, modes and sparse bit flips against a behavioural model evaluated every cycle.

// File: rtl/edac32_unit.sv
module edac32_unit #(
  parameter int DW = 32,
  parameter int CW = 8,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cbin,
  input  logic          in_le,
  input  logic          gen_n,
  input  logic          correct,
  input  logic [1:0]    code_sel,
  input  logic [1:0]    diag_mode,
  input  logic          diag_le,
  input  logic [NB-1:0] oe_byte_n,
  input  logic          oe_sc_n,
  output logic [DW-1:0] dout,
  output logic [NB-1:0] dout_en,
  output logic [CW-1:0] sc,
  output logic          sc_en,
  output logic          err_n,
  output logic          merr_n
);

  function automatic logic [CW-1:0] col_of(input int idx);
    logic [CW-1:0] r;
    logic [CW-1:0] t;
    int n;
    r = '0;
    n = 0;
    for (int v = 0; v < (1 << CW); v++) begin
      t = CW'(v);
      if ($countones(t) == 3) begin
        if (n == idx) r = t;
        n++;
      end
    end
    return r;
  endfunction

  logic [DW-1:0] data_q, out_q, hit, fixed;
  logic [CW-1:0] cb_q, dg_cb, gen_chk, cb_used, syn;
  logic [1:0]    dg_mode, eff_mode;
  logic          dg_corr, eff_corr, use_dg, chk_err, single;
  logic [CW-1:0] hcol [DW];

  for (genvar g = 0; g < DW; g++) begin : g_col
    assign hcol[g] = col_of(g);
    assign hit[g]  = (syn == hcol[g]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q <= '0;
      cb_q   <= '0;
    end else if (in_le) begin
      data_q <= din;
      cb_q   <= cbin;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dg_cb   <= '0;
      dg_mode <= '0;
      dg_corr <= 1'b0;
    end else if (diag_le) begin
      dg_cb   <= din[CW-1:0];
      dg_mode <= din[19:18];
      dg_corr <= din[20];
    end

  assign use_dg   = (code_sel == 2'b01);
  assign eff_mode = use_dg ? dg_mode : diag_mode;
  assign eff_corr = use_dg ? dg_corr : correct;
  assign cb_used  = (eff_mode != 2'b00) ? dg_cb : cb_q;

  always_comb begin
    gen_chk = '0;
    for (int i = 0; i < DW; i++)
      if (data_q[i]) gen_chk = gen_chk ^ hcol[i];
  end

  assign syn     = gen_chk ^ cb_used;
  assign single  = |hit;
  assign chk_err = ($countones(syn) == 1);
  assign fixed   = eff_corr ? (data_q ^ hit) : data_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_q <= '0;
    else if (gen_n) out_q <= fixed;

  assign dout    = out_q;
  assign dout_en = ~oe_byte_n;
  assign sc_en   = ~oe_sc_n;
  assign sc      = gen_n ? syn : gen_chk;
  assign err_n   = gen_n ? (syn == '0) : 1'b1;
  assign merr_n  = gen_n ? ((syn == '0) | single | chk_err) : 1'b1;

  assert_latch_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_le |=> $stable(data_q) && $stable(cb_q));
  assert_out_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_n |=> $stable(dout));
  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gen_n && err_n |=> dout == $past(data_q));
  assert_merr_in_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !merr_n |-> !err_n);
  assert_chk_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_n && chk_err |=> dout == $past(data_q));
  assert_diag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_le |=> $stable(dg_cb) && $stable(dg_mode) && $stable(dg_corr));

endmodule

// File: tb/edac32_unit_tb.sv
module edac32_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] din = '0;
  logic [7:0] cbin = '0;
  logic in_le = 0, gen_n = 1, correct = 0, diag_le = 0, oe_sc_n = 1;
  logic [1:0] code_sel = 0, diag_mode = 0;
  logic [3:0] oe_byte_n = 4'hF;
  logic [31:0] dout;
  logic [3:0] dout_en;
  logic [7:0] sc;
  logic sc_en, err_n, merr_n;

  edac32_unit dut_i (.clk, .rst_n, .din, .cbin, .in_le, .gen_n, .correct,
    .code_sel, .diag_mode, .diag_le, .oe_byte_n, .oe_sc_n,
    .dout, .dout_en, .sc, .sc_en, .err_n, .merr_n);

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [7:0] col [32];
  logic [31:0] m_data, m_out, m_diag;
  logic [7:0] m_cb;
  logic [31:0] e_fixed;
  logic [7:0] e_sc;
  logic e_err, e_merr;

  function automatic logic [7:0] chk(input logic [31:0] d);
    logic [7:0] r = '0;
    for (int i = 0; i < 32; i++) if (d[i]) r ^= col[i];
    return r;
  endfunction

  task automatic expect_now();
    logic [1:0] em;
    logic ec;
    logic [7:0] g, s;
    int idx;
    em = (code_sel == 2'b01) ? m_diag[19:18] : diag_mode;
    ec = (code_sel == 2'b01) ? m_diag[20] : correct;
    g = chk(m_data);
    s = g ^ ((em != 2'b00) ? m_diag[7:0] : m_cb);
    idx = -1;
    for (int k = 0; k < 32; k++) if (col[k] == s) idx = k;
    e_fixed = m_data;
    if (ec && idx >= 0) e_fixed[idx] = ~e_fixed[idx];
    e_sc   = gen_n ? s : g;
    e_err  = gen_n ? (s == 0) : 1'b1;
    e_merr = gen_n ? ((s == 0) || idx >= 0 || $countones(s) == 1) : 1'b1;
  endtask

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_data = '0; m_cb = '0; m_diag = '0; m_out = '0;
    end else begin
      expect_now();
      if (gen_n) m_out = e_fixed;
      if (in_le) begin m_data = din; m_cb = cbin; end
      if (diag_le) m_diag = din;
    end
    @(negedge clk);
    expect_now();
    vectors++;
    cmp("R1 R3 R4 R5 R7 R10 R12 dout", dout, m_out);
    cmp("R2 R4 R11 sc", {24'h0, sc}, {24'h0, e_sc});
    cmp("R2 R6 err_n", {31'h0, err_n}, {31'h0, e_err});
    cmp("R2 R6 merr_n", {31'h0, merr_n}, {31'h0, e_merr});
    cmp("R8 dout_en", {28'h0, dout_en}, {28'h0, ~oe_byte_n});
    cmp("R8 sc_en", {31'h0, sc_en}, {31'h0, ~oe_sc_n});
  endtask

  task automatic load(input logic [31:0] d, input logic [7:0] cb);
    din = d; cbin = cb; in_le = 1; step(); in_le = 0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n = 0;
    for (int v = 0; v < 256 && n < 32; v++)
      if ($countones(v[7:0]) == 3) begin col[n] = v[7:0]; n++; end
    // R12: reset state
    m_data = '0; m_cb = '0; m_diag = '0; m_out = '0;
    repeat (3) step();
    rst_n = 1; step();
    // R2, R3: generate mode with several words
    gen_n = 0; oe_byte_n = 4'h0; oe_sc_n = 0;
    load(32'h0000_0001, 8'h00); step();
    load(32'hDEAD_BEEF, 8'h00); step();
    load(32'hFFFF_FFFF, 8'h00); step();
    // R4, R6: clean codeword
    gen_n = 1; correct = 1;
    load(32'h1234_5678, chk(32'h1234_5678)); step();
    // R5: single data errors with correction on and off
    load(32'h1234_5678 ^ 32'h0000_0001, chk(32'h1234_5678)); step();
    load(32'h1234_5678 ^ 32'h8000_0000, chk(32'h1234_5678)); step();
    correct = 0; step(); correct = 1;
    // R7: check-bit-only error
    load(32'hA5A5_5A5A, chk(32'hA5A5_5A5A) ^ 8'h10); step();
    // R6: double error and unmatched weight-3 syndrome
    load(32'h0000_0003, 8'h00); step();
    load(32'h0000_0000, 8'hE0); step();
    // R1: hold while in_le low
    din = 32'hFFFF_0000; cbin = 8'h55; step(); step();
    // R8: byte enables patterns
    oe_byte_n = 4'b1010; oe_sc_n = 1; step(); oe_byte_n = 4'b0101; step();
    // R9, R10, R11: diagnostic latch routing
    din = 32'h0010_0000 | 32'h0004_0000 | chk(32'h0F0F_0F0F) ^ col[5];
    diag_le = 1; step(); diag_le = 0;
    correct = 0; load(32'h0F0F_0F0F, 8'h00); step();
    code_sel = 2'b01; step(); step();
    code_sel = 2'b00; diag_mode = 2'b11; step();
    diag_mode = 2'b00; step();
    // random phase
    for (int c = 0; c < 3000; c++) begin
      d = $urandom;
      din = d;
      cbin = chk(d);
      if ($urandom_range(0, 3) == 0) din[$urandom_range(0, 31)] ^= 1'b1;
      if ($urandom_range(0, 4) == 0) cbin[$urandom_range(0, 7)] ^= 1'b1;
      if ($urandom_range(0, 6) == 0) din[$urandom_range(0, 31)] ^= 1'b1;
      in_le = ($urandom_range(0, 3) != 0);
      diag_le = ($urandom_range(0, 15) == 0);
      gen_n = ($urandom_range(0, 4) != 0);
      correct = $urandom;
      code_sel = $urandom;
      diag_mode = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
      oe_byte_n = $urandom;
      oe_sc_n = $urandom;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule